// File: doc/BRIEF.md
# Transmit Frame Buffer Unpacker

This block turns a frame that software has laid out in a 16-bit packet buffer into a byte stream for a transmit MAC. Software fills the buffer and then pulses `start` with the frame's base word address. Word base+0 holds a status word that the block overwrites when it finishes. Word base+1 holds a byte count. Data words begin at base+2, and the frame ends with a control word. The data is sent exactly as stored: the six-byte destination address, the six-byte source address and then the payload. The block never substitutes an address of its own.

The buffer is read through a single read port whose data arrives one cycle after the request. The block reads the byte count first and then the control word, so it knows the exact frame length before the first byte leaves. It then fetches one data word at a time and sends each word as two bytes. A length outside the legal range ends the frame with an error status and sends nothing. When the frame is complete, a one-cycle write puts a status word into offset 0 of the frame.

Top module: `txu_unpacker`

## Requirements
- R1: After reset, `tx_valid`, `rd_en`, `st_we` and `busy` are all low.
- R2: A `start` pulse while idle causes a read of word base+1 (the byte count) in the same cycle. A `start` pulse while `busy` is high is ignored: the current frame is unchanged and no second frame follows.
- R3: Bit 0 of the stored byte count is treated as 0, whatever value is stored there.
- R4: With even count C (legal range 6 ≤ C ≤ MAX_BYTES), the block sends C−6 data bytes from words base+2 onward. Each word goes out low byte (bits 7:0) first, then high byte (bits 15:8).
- R5: The control word sits at base + C/2 − 1. Its bit 13 (bit 5 of its upper control byte) is the odd flag. When the flag is set, the control word's low byte is sent as one extra, final data byte.
- R6: `tx_last` is high only on the final byte of a frame. After that byte is accepted, `tx_valid` falls.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values and `rd_en` stays low.
- R8: If C < 6 or C > MAX_BYTES, no byte is sent. The status word written is 16'hC000 (bit 15 done, bit 14 length error, count field 0).
- R9: After the last byte is accepted, `st_we` pulses for exactly one cycle with `st_addr` = base and `st_data` = 16'h8000 | bytes sent (bit 15 done, bits 10:0 count). `busy` stays high until that pulse has ended.
- R10: A legal frame with C = 6 and the odd flag clear sends no byte and writes status 16'h8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a frame |
| start_base | input | ADDR_W | Word address of the frame's status word |
| busy | output | 1 | Frame in progress or status write pending |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | ADDR_W | Buffer read word address |
| rd_data | input | 16 | Read data, valid one cycle after `rd_en` |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Consumer accepts the byte |
| st_we | output | 1 | Status write strobe |
| st_addr | output | ADDR_W | Status write word address |
| st_data | output | 16 | Status word |

## Verification
The assertions are checked on every cycle. They cover the handshake rules: a stalled byte stays stable, no read is issued during a stall, the stream goes quiet after the last byte, and the status strobe lasts a single cycle and never overlaps the stream. They also check that a length error is followed at once by an error status with a zero count and that `busy` covers all activity. Other properties need stored frames to show them: the byte order, the position of the odd byte, the even-count rounding, the exact count limits and the fact that a late `start` is ignored. The bench shows these by sweeping every raw byte count from 0 to 71, both odd-flag values and three ready patterns, and by running frames at and just beyond the maximum length.

// File: rtl/txu_pkg.sv
package txu_pkg;

  localparam int unsigned TXU_HDR_BYTES = 6;
  localparam int unsigned TXU_ODD_BIT   = 13;
  localparam int unsigned TXU_ST_DONE   = 15;
  localparam int unsigned TXU_ST_LENERR = 14;
  localparam int unsigned TXU_ST_CNT_W  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_CTL,
    ST_FILL,
    ST_SEND,
    ST_DONE
  } txu_state_e;

  // stored count with its lowest bit cleared
  function automatic logic [15:0] txu_even_count(input logic [15:0] raw);
    return {raw[15:1], 1'b0};
  endfunction

  // legal range check on an already evened count
  function automatic logic txu_count_ok(input logic [15:0] cnt, input int unsigned max_bytes);
    return (32'(cnt) >= TXU_HDR_BYTES) && (32'(cnt) <= max_bytes);
  endfunction

  // completion word written back to offset 0
  function automatic logic [15:0] txu_status_word(input logic err, input logic [15:0] sent);
    logic [15:0] w;
    w = '0;
    w[TXU_ST_DONE]   = 1'b1;
    w[TXU_ST_LENERR] = err;
    w[TXU_ST_CNT_W-1:0] = sent[TXU_ST_CNT_W-1:0];
    return w;
  endfunction

endpackage

// File: rtl/txu_len_decode.sv
module txu_len_decode
  import txu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MAX_BYTES = 2048,
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic [15:0]       raw_count,
  output logic              count_ok,
  output logic [ADDR_W-1:0] word_total,
  output logic [CNT_W-1:0]  payload_even
);

  logic [15:0] even_c;

  assign even_c       = txu_even_count(raw_count);
  assign count_ok     = txu_count_ok(even_c, MAX_BYTES);
  assign word_total   = ADDR_W'(even_c >> 1);
  assign payload_even = CNT_W'(even_c - 16'(TXU_HDR_BYTES));

endmodule

// File: rtl/txu_engine.sv
module txu_engine
  import txu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MAX_BYTES = 2048,
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              fin,
  output logic              fin_err,
  output logic [CNT_W-1:0]  fin_count,
  output logic [ADDR_W-1:0] fin_base,
  output logic              busy
);

  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO_A = ADDR_W'(2);

  txu_state_e        state_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  words_left_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  sent_q;
  logic [15:0]       hold_q;
  logic              hi_sel_q;
  logic [7:0]        ctl_lo_q;
  logic              err_q;

  logic              cnt_ok;
  logic [ADDR_W-1:0] cnt_words;
  logic [CNT_W-1:0]  cnt_payload;
  logic              byte_fire;
  logic              odd_flag;
  logic              more_words;

  txu_len_decode #(
    .ADDR_W   (ADDR_W),
    .MAX_BYTES(MAX_BYTES)
  ) u_len (
    .raw_count   (rd_data),
    .count_ok    (cnt_ok),
    .word_total  (cnt_words),
    .payload_even(cnt_payload)
  );

  assign byte_fire  = out_valid & out_ready;
  assign odd_flag   = rd_data[TXU_ODD_BIT];
  assign more_words = (words_left_q != '0);

  // read request generation
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = ptr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          rd_en   = 1'b1;
          rd_addr = base + ONE_A;
        end
      end
      ST_CNT: begin
        if (cnt_ok) begin
          rd_en   = 1'b1;
          rd_addr = base_q + cnt_words - ONE_A;
        end
      end
      ST_CTL: begin
        if (more_words) rd_en = 1'b1;
      end
      ST_SEND: begin
        if (byte_fire && hi_sel_q && (rem_q != ONE_C) && more_words) rd_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      base_q       <= '0;
      ptr_q        <= '0;
      words_left_q <= '0;
      rem_q        <= '0;
      sent_q       <= '0;
      hold_q       <= '0;
      hi_sel_q     <= 1'b0;
      ctl_lo_q     <= '0;
      err_q        <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q  <= base;
            err_q   <= 1'b0;
            sent_q  <= '0;
            state_q <= ST_CNT;
          end
        end
        ST_CNT: begin
          if (!cnt_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            words_left_q <= cnt_payload >> 1;
            rem_q        <= cnt_payload;
            ptr_q        <= base_q + TWO_A;
            state_q      <= ST_CTL;
          end
        end
        ST_CTL: begin
          ctl_lo_q <= rd_data[7:0];
          rem_q    <= rem_q + CNT_W'(odd_flag);
          if (more_words) begin
            ptr_q        <= ptr_q + ONE_A;
            words_left_q <= words_left_q - ONE_C;
            state_q      <= ST_FILL;
          end else if (odd_flag) begin
            hold_q   <= {8'h00, rd_data[7:0]};
            hi_sel_q <= 1'b0;
            state_q  <= ST_SEND;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_FILL: begin
          hold_q   <= rd_data;
          hi_sel_q <= 1'b0;
          state_q  <= ST_SEND;
        end
        ST_SEND: begin
          if (byte_fire) begin
            rem_q  <= rem_q - ONE_C;
            sent_q <= sent_q + ONE_C;
            if (rem_q == ONE_C) begin
              state_q <= ST_DONE;
            end else if (hi_sel_q) begin
              if (more_words) begin
                ptr_q        <= ptr_q + ONE_A;
                words_left_q <= words_left_q - ONE_C;
                state_q      <= ST_FILL;
              end else begin
                hold_q   <= {8'h00, ctl_lo_q};
                hi_sel_q <= 1'b0;
              end
            end else begin
              hi_sel_q <= 1'b1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state_q == ST_SEND);
  assign out_data  = hi_sel_q ? hold_q[15:8] : hold_q[7:0];
  assign out_last  = out_valid && (rem_q == ONE_C);
  assign fin       = (state_q == ST_DONE);
  assign fin_err   = err_q;
  assign fin_count = sent_q;
  assign fin_base  = base_q;
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/txu_status_wr.sv
module txu_status_wr
  import txu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic              fin_err,
  input  logic [CNT_W-1:0]  fin_count,
  input  logic [ADDR_W-1:0] fin_base,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [15:0]       st_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_we   <= 1'b0;
      st_addr <= '0;
      st_data <= '0;
    end else begin
      st_we <= fin;
      if (fin) begin
        st_addr <= fin_base;
        st_data <= txu_status_word(fin_err, 16'(fin_count));
      end
    end
  end

endmodule

// File: rtl/txu_unpacker.sv
module txu_unpacker
  import txu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MAX_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [15:0]       st_data
);

  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

  logic              start_ok;
  logic              eng_busy;
  logic              fin;
  logic              fin_err;
  logic [CNT_W-1:0]  fin_count;
  logic [ADDR_W-1:0] fin_base;
  logic              fin_err_ev;

  // no new frame while the previous status write is still going out
  assign start_ok   = start & ~st_we;
  assign fin_err_ev = fin & fin_err;

  txu_engine #(
    .ADDR_W   (ADDR_W),
    .MAX_BYTES(MAX_BYTES)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ok),
    .base     (start_base),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .out_last (tx_last),
    .out_ready(tx_ready),
    .fin      (fin),
    .fin_err  (fin_err),
    .fin_count(fin_count),
    .fin_base (fin_base),
    .busy     (eng_busy)
  );

  txu_status_wr #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .fin_err  (fin_err),
    .fin_count(fin_count),
    .fin_base (fin_base),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_data  (st_data)
  );

  assign busy = eng_busy | st_we;

endmodule

// File: rtl/txu_checker.sv
module txu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_en,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_ready,
  input logic        st_we,
  input logic [15:0] st_data,
  input logic        len_err_ev
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!tx_valid && !st_we && !busy));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_no_fetch_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |-> !rd_en);

  assert_quiet_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  assert_single_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |=> !st_we);

  assert_status_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> !tx_valid);

  assert_busy_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || st_we) |-> busy);

  assert_err_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_ev |=> (st_we && st_data[14] && (st_data[10:0] == 11'd0)));

endmodule

bind txu_unpacker txu_checker u_txu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .rd_en     (rd_en),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .tx_ready  (tx_ready),
  .st_we     (st_we),
  .st_data   (st_data),
  .len_err_ev(fin_err_ev)
);

// File: tb/txu_unpacker_tb.sv
`timescale 1ns/1ps
module txu_unpacker_tb_top;

  localparam int AW   = 12;
  localparam int MAXB = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_base = '0;
  logic          busy;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data = '0;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          tx_last;
  logic          tx_ready = 1'b0;
  logic          st_we;
  logic [AW-1:0] st_addr;
  logic [15:0]   st_data;

  logic [15:0] mem [0:(1<<AW)-1];
  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit wd_hit  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    cycles <= cycles + 1;
  end

  txu_unpacker #(.ADDR_W(AW), .MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int base, input int raw, input bit odd, input int pat, input bit poke);
    int  bcz, nd, tot, got, bad_k, bad_v, bad_e, lastbad, stallbad, cyc, exp_st;
    bit  valid, seen_st;
    logic [7:0] seed, eb;
    bcz   = raw & 32'hFFFE;
    valid = (bcz >= 6) && (bcz <= MAXB);
    nd    = valid ? bcz - 6 : 0;
    tot   = valid ? nd + int'(odd) : 0;
    seed  = 8'((base * 7 + raw) & 255);
    mem[base]   = 16'hFFFF;
    mem[base+1] = 16'(raw);
    if (valid) begin
      for (int i = 0; i < nd / 2; i++)
        mem[base+2+i] = {8'(seed + 8'(2*i+1)), 8'(seed + 8'(2*i))};
      mem[base + bcz/2 - 1] = {(odd ? 8'hA5 : 8'h5A), seed ^ 8'h5C};
      mem[base + bcz/2]     = 16'hDEAD;
    end
    @(negedge clk);
    start = 1'b1;
    start_base = AW'(base);
    #1;
    check(rd_en && (rd_addr == AW'(base + 1)), "R2", "first read address", int'(rd_addr), base + 1);
    got = 0; bad_k = -1; bad_v = 0; bad_e = 0; lastbad = 0; stallbad = 0; cyc = 0; seen_st = 0;
    while (!seen_st && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      start = poke && (cyc == 3);
      start_base = (poke && cyc == 3) ? AW'(base + 50) : AW'(base);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (pat)
        0: tx_ready = 1'b1;
        1: tx_ready = cyc[0];
        default: tx_ready = lfsr[0];
      endcase
      #1;
      if (tx_valid && tx_ready) begin
        eb = (got < nd) ? 8'(seed + 8'(got)) : (seed ^ 8'h5C);
        if (got >= tot || tx_data != eb) begin
          if (bad_k < 0) begin bad_k = got; bad_v = tx_data; bad_e = eb; end
        end
        if (tx_last != (got == tot - 1)) lastbad++;
        got++;
      end
      if (tx_valid && !tx_ready && rd_en) stallbad++;
      if (st_we) begin
        seen_st = 1;
        exp_st = valid ? (32'h8000 | tot) : 32'hC000;
        check(st_addr == AW'(base), "R9", "status address", int'(st_addr), base);
        check(int'(st_data) == exp_st, valid ? "R9" : "R8", "status word", int'(st_data), exp_st);
      end
    end
    start = 1'b0;
    check(seen_st, "R9", "status write seen", int'(seen_st), 1);
    check(bad_k < 0, odd ? "R5" : "R4", "byte value", bad_v, bad_e);
    check(got == tot, (tot == 0) ? (valid ? "R10" : "R8") : "R4", "byte count", got, tot);
    check(lastbad == 0, "R6", "last marker errors", lastbad, 0);
    check(stallbad == 0, "R7", "reads during stall", stallbad, 0);
    @(negedge clk);
    #1;
    check(!busy && !tx_valid, "R9", "idle after status", int'(busy), 0);
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        #1;
        check(!tx_valid && !st_we && !busy, "R2", "start while busy ignored", int'(busy), 0);
      end
    end
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) mem[a] = 16'h0BAD;
    repeat (3) @(negedge clk);
    #1;
    check(!tx_valid && !rd_en && !st_we && !busy, "R1", "outputs during reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!tx_valid && !rd_en && !st_we && !busy, "R1", "outputs after reset", int'(busy), 0);
    // raw counts 0..71 cover odd raw values (R3), zero payload (R10) and short errors (R8)
    for (int raw = 0; raw < 72; raw++)
      for (int od = 0; od < 2; od++)
        for (int pat = 0; pat < 3; pat++)
          run_frame((raw * 13 + pat * 5) % 512 + 8, raw, od[0], pat,
                    (pat == 1) && (raw >= 20) && (od == 1));
    run_frame(1000, 2048, 1'b1, 0, 1'b0);  // R4 upper limit with odd byte
    run_frame(1000, 2049, 1'b0, 2, 1'b0);  // R3 rounds down to the limit
    run_frame(1000, 2050, 1'b1, 1, 1'b0);  // R8 just over the limit
    run_frame(700, 65535, 1'b0, 0, 1'b0);  // R8 far over
    run_frame(700, 5, 1'b1, 0, 1'b0);      // R8 short
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles >= 190000 && !wd_hit) begin
      wd_hit = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule